// File: doc/BRIEF.md
# Ethernet receive error statistics counters

This block keeps three statistics for an Ethernet receive path: frames that failed their CRC check, assertions of the receive-error line from the PHY, and runt frames shorter than the 64-byte minimum. The receive MAC gives it a one-cycle end-of-frame strobe. The CRC-bad flag and the frame byte count are valid alongside that strobe. The raw PHY receive-error level arrives on its own input. Frame parsing, CRC computation and the PHY interface itself sit outside this block.

Each counter is 32 bits wide by default. A counter sticks at all-ones instead of wrapping. Software reads the counters through a small register port. A write to a counter's address clears that counter and discards the write data. Read data is registered and appears one clock after the address is presented.

Top module: `rx_err_stats`

## Requirements
- R1: After a synchronous reset, all three counters are zero and `rd_data` is zero.
- R2: The CRC-error counter (byte offset 0x0) increments by one in each cycle where `eof` is high and `crc_bad` is high. `crc_bad` has no effect without `eof`.
- R3: The runt counter (byte offset 0x8) increments by one in each cycle where `eof` is high and `frame_len` is below 64. A length of exactly 64 does not count, and neither does a short length without `eof`.
- R4: A frame that is both CRC-bad and shorter than 64 bytes increments the CRC-error counter and the runt counter in the same cycle.
- R5: The receive-error counter (byte offset 0x4) increments once for each rising transition of `phy_rxerr`. The transition is judged against the level registered on the previous clock, so holding the line high for any number of cycles adds exactly one.
- R6: A counter that holds all-ones keeps that value when further events arrive, until it is cleared.
- R7: A write (`wr_en` high) to a counter's offset sets that counter to zero whatever `wr_data` holds. The other counters are not affected.
- R8: When a clearing write and an increment event reach the same counter in the same cycle, the clear takes effect and the counter reads zero afterwards.
- R9: `rd_data` is registered. One clock after `addr` is presented, `rd_data` holds the zero-extended count that the addressed counter had in that cycle, with offsets 0x0 for CRC errors, 0x4 for receive errors and 0x8 for runts. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eof | input | 1 | One-cycle end-of-frame strobe from the receive MAC |
| crc_bad | input | 1 | CRC check failed for the frame ending this cycle; valid with `eof` |
| frame_len | input | LEN_W (16) | Byte count of the frame ending this cycle; valid with `eof` |
| phy_rxerr | input | 1 | Receive-error level from the PHY |
| addr | input | ADDR_W (8) | Register byte offset for read and clear |
| wr_en | input | 1 | Write strobe; clears the addressed counter |
| wr_data | input | DATA_W (32) | Write data, ignored |
| rd_data | output | DATA_W (32) | Registered read data |

## Verification
A clearing write can land in the same cycle as an increment event for the same counter. The bench provokes this twice. In one case it drives a CRC-bad end-of-frame together with a write to offset 0x0. In the other it raises `phy_rxerr` in the same cycle as a write to offset 0x4. In both cases the following read must return zero, and a later write to that counter from a saturated state must still clear it. The bench runs its counters at 8 bits so that saturation can be reached in a few hundred frames, and it compares every cycle against a behavioural model.

// File: rtl/rx_err_stats_pkg.sv
package rx_err_stats_pkg;
  // Counter slots; the slot index times 4 is the byte offset of the register.
  localparam int NUM_CNT  = 3;
  localparam int SLOT_CRC = 0;
  localparam int SLOT_RXE = 1;
  localparam int SLOT_RUNT = 2;
  localparam int OFS_STEP = 4;
endpackage

// File: rtl/rx_err_rise_det.sv
module rx_err_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic level_q
);
  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= din;
  end

  assign rise = din & ~level_q;
endmodule

// File: rtl/rx_err_sat_cnt.sv
module rx_err_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc && (count != TOP))
      count <= count + 1'b1;
  end
endmodule

// File: rtl/rx_err_rd_mux.sv
module rx_err_rd_mux #(
  parameter int W      = 32,
  parameter int N      = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N*W-1:0]    cnt_flat,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (addr == ADDR_W'(STEP * i))
        sel = DATA_W'(cnt_flat[i*W +: W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end
endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats
  import rx_err_stats_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eof,
  input  logic              crc_bad,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              phy_rxerr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [LEN_W-1:0] RUNT_LIMIT = LEN_W'(MIN_LEN);

  logic [NUM_CNT-1:0]       evt;
  logic [NUM_CNT-1:0]       clr;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [CNT_W-1:0]         cnt_vec [NUM_CNT];
  logic                     rxe_rise;
  logic                     rxe_q;
  logic                     unused_wdata;

  // Write data carries no meaning: a write only clears.
  assign unused_wdata = ^wr_data;

  rx_err_rise_det u_rise (
    .clk    (clk),
    .rst    (rst),
    .din    (phy_rxerr),
    .rise   (rxe_rise),
    .level_q(rxe_q)
  );

  assign evt[SLOT_CRC]  = eof & crc_bad;
  assign evt[SLOT_RXE]  = rxe_rise;
  assign evt[SLOT_RUNT] = eof & (frame_len < RUNT_LIMIT);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign clr[i] = wr_en && (addr == ADDR_W'(OFS_STEP * i));

    rx_err_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr[i]),
      .inc  (evt[i]),
      .count(cnt_vec[i])
    );

    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_vec[i];
  end

  rx_err_rd_mux #(
    .W     (CNT_W),
    .N     (NUM_CNT),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .STEP  (OFS_STEP)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .cnt_flat(cnt_flat),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/rx_err_stats_chk.sv
module rx_err_stats_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  cnt_crc,
  input logic [CNT_W-1:0]  cnt_rxe,
  input logic [CNT_W-1:0]  cnt_runt,
  input logic              rxe_q
);
  localparam logic [CNT_W-1:0]  MAXV   = {CNT_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_CRC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RXE  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RUNT = ADDR_W'(8);

  logic wr_crc, wr_rxe, wr_runt, mapped;
  assign wr_crc  = wr_en && (addr == A_CRC);
  assign wr_rxe  = wr_en && (addr == A_RXE);
  assign wr_runt = wr_en && (addr == A_RUNT);
  assign mapped  = (addr == A_CRC) || (addr == A_RXE) || (addr == A_RUNT);

  // R2: without a clear the CRC count only holds or steps by one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_crc |=> (cnt_crc == $past(cnt_crc)) || (cnt_crc == CNT_W'($past(cnt_crc) + 1'b1)));

  // R3: without a clear the runt count only holds or steps by one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_runt |=> (cnt_runt == $past(cnt_runt)) || (cnt_runt == CNT_W'($past(cnt_runt) + 1'b1)));

  // R5: a level that was already high last clock adds nothing
  p_rxe_once_r5: assert property (@(posedge clk) disable iff (rst)
    (rxe_q && !wr_rxe) |=> cnt_rxe == $past(cnt_rxe));

  // R6: saturated counters hold
  p_sat_crc_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_crc == MAXV && !wr_crc) |=> cnt_crc == MAXV);
  p_sat_runt_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_runt == MAXV && !wr_runt) |=> cnt_runt == MAXV);

  // R7: a write clears its counter
  p_clear_rxe_r7: assert property (@(posedge clk) disable iff (rst)
    wr_rxe |=> cnt_rxe == '0);
  p_clear_runt_r7: assert property (@(posedge clk) disable iff (rst)
    wr_runt |=> cnt_runt == '0);

  // R8: the clear wins even with a same-cycle CRC event
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
    wr_crc |=> cnt_crc == '0);

  // R9: unmapped offsets read zero
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> rd_data == '0);
endmodule

bind rx_err_stats rx_err_stats_chk #(
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .rd_data (rd_data),
  .cnt_crc (cnt_vec[0]),
  .cnt_rxe (cnt_vec[1]),
  .cnt_runt(cnt_vec[2]),
  .rxe_q   (rxe_q)
);

// File: tb/rx_err_stats_test.sv
module rx_err_stats_test;
  localparam int CW = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eof = 1'b0;
  logic        crc_bad = 1'b0;
  logic [15:0] frame_len = '0;
  logic        phy_rxerr = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  rx_err_stats #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .eof(eof), .crc_bad(crc_bad), .frame_len(frame_len),
    .phy_rxerr(phy_rxerr), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data)
  );

  // Behavioural reference model
  int unsigned m [3];
  bit          mq;
  logic [31:0] exp_rd = '0;

  always @(posedge clk) begin
    bit inc [3];
    if (rst) begin
      for (int i = 0; i < 3; i++) m[i] = 0;
      mq = 1'b0;
      exp_rd = '0;
    end else begin
      exp_rd = (addr == 8'h0) ? m[0] : (addr == 8'h4) ? m[1] : (addr == 8'h8) ? m[2] : 32'h0;
      inc[0] = eof && crc_bad;
      inc[1] = phy_rxerr && !mq;
      inc[2] = eof && (frame_len < 16'd64);
      for (int i = 0; i < 3; i++) begin
        if (wr_en && addr == 8'(4 * i)) m[i] = 0;
        else if (inc[i] && m[i] < MAXC) m[i] = m[i] + 1;
      end
      mq = phy_rxerr;
    end
  end

  always @(negedge clk) begin
    if (live && !rst && !done) begin
      checks++;
      if (rd_data !== exp_rd) begin
        errors++;
        $display("FAIL %s model: rd_data=%0h expected %0h", phase, rd_data, exp_rd);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int len, input bit bad);
    @(negedge clk);
    eof = 1'b1; crc_bad = bad; frame_len = 16'(len);
    @(negedge clk);
    eof = 1'b0; crc_bad = 1'b0; frame_len = '0;
  endtask

  task automatic rx_pulse(input int w);
    @(negedge clk);
    phy_rxerr = 1'b1;
    repeat (w) @(negedge clk);
    phy_rxerr = 1'b0;
  endtask

  task automatic clear_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic read_check(input logic [7:0] a, input int unsigned exp, input string tag);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    checks++;
    if (rd_data !== 32'(exp)) begin
      errors++;
      $display("FAIL %s read %0h: rd_data=%0h expected %0h", tag, a, rd_data, exp);
    end
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    live = 1'b1;

    phase = "R1";
    read_check(8'h0, 0, "R1");
    read_check(8'h4, 0, "R1");
    read_check(8'h8, 0, "R1");

    phase = "R2";
    for (int k = 0; k < 3; k++) frame(100, 1'b1);
    @(negedge clk); crc_bad = 1'b1; frame_len = 16'd100;
    @(negedge clk); crc_bad = 1'b0; frame_len = '0;
    read_check(8'h0, 3, "R2");
    read_check(8'h8, 0, "R2");

    phase = "R3";
    frame(63, 1'b0);
    frame(64, 1'b0);
    frame(10, 1'b0);
    @(negedge clk); frame_len = 16'd5;
    @(negedge clk); frame_len = '0;
    read_check(8'h8, 2, "R3");
    read_check(8'h0, 3, "R3");

    phase = "R4";
    frame(20, 1'b1);
    read_check(8'h0, 4, "R4");
    read_check(8'h8, 3, "R4");

    phase = "R5";
    rx_pulse(5); idle(1);
    rx_pulse(1); idle(2);
    rx_pulse(3); idle(1);
    read_check(8'h4, 3, "R5");

    phase = "R9";
    read_check(8'hC, 0, "R9");
    read_check(8'h2, 0, "R9");
    read_check(8'h4, 3, "R9");

    phase = "R7";
    clear_reg(8'h4, 32'hFFFF_FFFF);
    read_check(8'h4, 0, "R7");
    read_check(8'h0, 4, "R7");
    read_check(8'h8, 3, "R7");

    phase = "R8";
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h0; eof = 1'b1; crc_bad = 1'b1; frame_len = 16'd200;
    @(negedge clk);
    wr_en = 1'b0; eof = 1'b0; crc_bad = 1'b0; frame_len = '0;
    read_check(8'h0, 0, "R8");
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h4; phy_rxerr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    idle(2);
    phy_rxerr = 1'b0;
    read_check(8'h4, 0, "R8");
    read_check(8'h8, 3, "R8");

    phase = "R6";
    for (int k = 0; k < 300; k++) frame(20, 1'b1);
    read_check(8'h0, MAXC, "R6");
    read_check(8'h8, MAXC, "R6");
    clear_reg(8'h0, 32'h1234_5678);
    frame(30, 1'b0);
    read_check(8'h0, 0, "R6");
    read_check(8'h8, MAXC, "R6");
    clear_reg(8'h8, 32'h0);
    read_check(8'h8, 0, "R7");

    idle(2);
    finish_run();
  end
endmodule